// File: doc/BRIEF.md
# Debug Controller Status, Control and Match-Address Registers

This block holds the two registers of a serial background debug controller: an 8-bit status/control word and a 16-bit breakpoint match address. Neither register sits in the target's memory map. A command decoder, which is outside this block, reaches them through single-cycle strobes: a status read, a control write, a match-address write and a match-address read. The block applies a fixed write mask and a state-dependent lock to the control word. Each cycle it samples four status indications from the core. It drives the enables that the debug logic around it consumes: permission to halt, breakpoint enable, forced tagging and clock selection.

Two synchronous resets exist. A normal reset clears everything. A halt-entry reset loads an image that marks the core as halted and already permitted to be halted. The block carries no data stream. Every command is a one-cycle strobe that is accepted in the cycle it is raised. There is no valid/ready pairing and no back-pressure, so the decoder may issue a command on any cycle.

Top module: `dbgctl_regs`

## Requirements
- R1: While `rst_norm_i` is high at a clock edge, the status/control word becomes 0x00 and the match address becomes 0x0000.
- R2: While only `rst_halt_i` is high at a clock edge, the status/control word becomes 0xC8 and the match address becomes 0x0000. In 0xC8, bit 7 (halt permit), bit 6 (halted flag) and bit 3 (clock select) are 1 and all other bits are 0.
- R3: Outside reset, bits 6, 2, 1 and 0 of the status/control word take the values of `core_halted_i`, `core_wait_i`, `core_stopfail_i` and `core_dvfail_i` sampled at the previous clock edge.
- R4: A control write never changes bits 6, 2, 1 or 0. Those positions of `ctl_wdata_i` are discarded.
- R5: A control write with bit 7 = 1 while the halted flag (bit 6) is 0 sets the permit bit. Once set, the permit bit stays 1 until a normal reset, and a write of 0 to bit 7 does not clear it.
- R6: While the halted flag is 1, a control write leaves the permit bit unchanged.
- R7: Each control write loads bit 5 (breakpoint enable), bit 4 (force tag) and bit 3 (clock select) from `ctl_wdata_i`, whatever the state.
- R8: `stat_rdata_o` presents the current status/control word in the same cycle that `stat_rd_i` is high, and reads 0x00 otherwise. `bp_rdata_o` behaves the same way for the match address under `bp_rd_i`.
- R9: A match-address write loads `bp_wdata_i` into the match address register at that edge.
- R10: `halt_permit_o`, `bp_enable_o`, `force_tag_o` and `clk_sel_o` always equal bits 7, 5, 4 and 3 of the status/control word, and `bp_addr_o` always equals the match address.
- R11: When both resets are high together, the normal reset wins and the word becomes 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_norm_i | input | 1 | Synchronous normal reset, active high |
| rst_halt_i | input | 1 | Synchronous reset into halted mode, active high |
| core_halted_i | input | 1 | Core is in halted debug mode |
| core_wait_i | input | 1 | Core is in a wait/stop state |
| core_stopfail_i | input | 1 | A wait/stop entry failed |
| core_dvfail_i | input | 1 | A data-valid failure occurred |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 8 | Control write data |
| stat_rd_i | input | 1 | Status read strobe |
| stat_rdata_o | output | 8 | Status/control read data |
| bp_wr_i | input | 1 | Match-address write strobe |
| bp_wdata_i | input | AW | Match-address write data |
| bp_rd_i | input | 1 | Match-address read strobe |
| bp_rdata_o | output | AW | Match-address read data |
| halt_permit_o | output | 1 | Halting-mode commands permitted |
| bp_enable_o | output | 1 | Breakpoint enable |
| force_tag_o | output | 1 | Force-tag select |
| clk_sel_o | output | 1 | Clock select |
| bp_addr_o | output | AW | Current match address |

## Verification
Every cycle, the assertions check four things: the one-cycle tracking of the core status inputs, that the permit bit never falls outside a normal reset, the halted-flag lock on the permit bit, and that writes land in the clock-select bit and the match address. The reset images, the priority between the two resets, the masking of all 256 write patterns and the zeroing of read data without a strobe can only be shown by the bench scenarios. Those scenarios compare the ports against an arithmetic model.

// File: rtl/dbgctl_pkg.sv
package dbgctl_pkg;
  localparam int unsigned WORD_W = 8;
  // bit positions of the status/control word
  localparam int unsigned B_PERMIT = 7;
  localparam int unsigned B_HALTED = 6;
  localparam int unsigned B_BPEN   = 5;
  localparam int unsigned B_FTAG   = 4;
  localparam int unsigned B_CLKSEL = 3;
  localparam int unsigned B_WAIT   = 2;
  localparam int unsigned B_SFAIL  = 1;
  localparam int unsigned B_DVFAIL = 0;
  localparam int unsigned NSTAT    = 4;

  typedef struct packed {
    logic permit;
    logic bpen;
    logic ftag;
    logic clksel;
  } ctl_bits_t;

  // status vector order: halted, wait, stop-fail, data-valid fail
  typedef logic [NSTAT-1:0] stat_vec_t;

  function automatic logic [WORD_W-1:0] pack_word(ctl_bits_t c, stat_vec_t s);
    logic [WORD_W-1:0] w;
    w           = '0;
    w[B_PERMIT] = c.permit;
    w[B_HALTED] = s[3];
    w[B_BPEN]   = c.bpen;
    w[B_FTAG]   = c.ftag;
    w[B_CLKSEL] = c.clksel;
    w[B_WAIT]   = s[2];
    w[B_SFAIL]  = s[1];
    w[B_DVFAIL] = s[0];
    return w;
  endfunction
endpackage

// File: rtl/dbgctl_status_cap.sv
module dbgctl_status_cap
  import dbgctl_pkg::*;
#(
  parameter int unsigned         N        = NSTAT,
  parameter logic [NSTAT-1:0]    HALT_IMG = 4'b1000
) (
  input  logic         clk_i,
  input  logic         rst_norm_i,
  input  logic         rst_halt_i,
  input  logic [N-1:0] core_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (rst_norm_i)      stat_q[g] <= 1'b0;
      else if (rst_halt_i) stat_q[g] <= HALT_IMG[g];
      else                 stat_q[g] <= core_i[g];
    end
  end

  assign stat_o = stat_q;

  p_track_core_r3: assert property (@(posedge clk_i)
    disable iff (rst_norm_i || rst_halt_i)
    1'b1 |=> (stat_q == $past(core_i)))
    else $error("status bits did not follow core inputs");
endmodule

// File: rtl/dbgctl_ctrl_bits.sv
module dbgctl_ctrl_bits
  import dbgctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_norm_i,
  input  logic              rst_halt_i,
  input  logic              halted_q_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output ctl_bits_t         ctl_o
);
  ctl_bits_t ctl_q, ctl_d;
  logic      permit_set;

  // permit bit can only be set, and only when not halted
  assign permit_set = wr_i && wdata_i[B_PERMIT] && !halted_q_i;

  always_comb begin
    ctl_d        = ctl_q;
    ctl_d.permit = ctl_q.permit | permit_set;
    if (wr_i) begin
      ctl_d.bpen   = wdata_i[B_BPEN];
      ctl_d.ftag   = wdata_i[B_FTAG];
      ctl_d.clksel = wdata_i[B_CLKSEL];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_norm_i)      ctl_q <= '{permit: 1'b0, bpen: 1'b0, ftag: 1'b0, clksel: 1'b0};
    else if (rst_halt_i) ctl_q <= '{permit: 1'b1, bpen: 1'b0, ftag: 1'b0, clksel: 1'b1};
    else                 ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  p_permit_sticky_r5: assert property (@(posedge clk_i)
    disable iff (rst_norm_i)
    ctl_q.permit |=> ctl_q.permit)
    else $error("permit bit cleared outside normal reset");

  p_permit_lock_r6: assert property (@(posedge clk_i)
    disable iff (rst_norm_i || rst_halt_i)
    (wr_i && halted_q_i && !ctl_q.permit) |=> !ctl_q.permit)
    else $error("permit bit written while halted");

  p_clksel_write_r7: assert property (@(posedge clk_i)
    disable iff (rst_norm_i || rst_halt_i)
    wr_i |=> (ctl_q.clksel == $past(wdata_i[B_CLKSEL])))
    else $error("clock select not loaded by write");
endmodule

// File: rtl/dbgctl_match_reg.sv
module dbgctl_match_reg #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_any_i,
  input  logic          wr_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i) begin
    if (rst_any_i) addr_q <= '0;
    else if (wr_i) addr_q <= wdata_i;
  end

  assign addr_o = addr_q;

  p_match_load_r9: assert property (@(posedge clk_i)
    disable iff (rst_any_i)
    wr_i |=> (addr_q == $past(wdata_i)))
    else $error("match address not loaded");
endmodule

// File: rtl/dbgctl_regs.sv
module dbgctl_regs
  import dbgctl_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_norm_i,
  input  logic              rst_halt_i,
  input  logic              core_halted_i,
  input  logic              core_wait_i,
  input  logic              core_stopfail_i,
  input  logic              core_dvfail_i,
  input  logic              ctl_wr_i,
  input  logic [WORD_W-1:0] ctl_wdata_i,
  input  logic              stat_rd_i,
  output logic [WORD_W-1:0] stat_rdata_o,
  input  logic              bp_wr_i,
  input  logic [AW-1:0]     bp_wdata_i,
  input  logic              bp_rd_i,
  output logic [AW-1:0]     bp_rdata_o,
  output logic              halt_permit_o,
  output logic              bp_enable_o,
  output logic              force_tag_o,
  output logic              clk_sel_o,
  output logic [AW-1:0]     bp_addr_o
);
  stat_vec_t         core_vec, stat_vec;
  ctl_bits_t         ctl;
  logic [WORD_W-1:0] word;
  logic [AW-1:0]     match;

  assign core_vec = {core_halted_i, core_wait_i, core_stopfail_i, core_dvfail_i};

  dbgctl_status_cap #(.N(NSTAT), .HALT_IMG(4'b1000)) u_stat (
    .clk_i      (clk_i),
    .rst_norm_i (rst_norm_i),
    .rst_halt_i (rst_halt_i),
    .core_i     (core_vec),
    .stat_o     (stat_vec)
  );

  dbgctl_ctrl_bits u_ctl (
    .clk_i      (clk_i),
    .rst_norm_i (rst_norm_i),
    .rst_halt_i (rst_halt_i),
    .halted_q_i (stat_vec[3]),
    .wr_i       (ctl_wr_i),
    .wdata_i    (ctl_wdata_i),
    .ctl_o      (ctl)
  );

  dbgctl_match_reg #(.AW(AW)) u_match (
    .clk_i     (clk_i),
    .rst_any_i (rst_norm_i || rst_halt_i),
    .wr_i      (bp_wr_i),
    .wdata_i   (bp_wdata_i),
    .addr_o    (match)
  );

  assign word          = pack_word(ctl, stat_vec);
  assign stat_rdata_o  = stat_rd_i ? word  : '0;
  assign bp_rdata_o    = bp_rd_i   ? match : '0;
  assign halt_permit_o = ctl.permit;
  assign bp_enable_o   = ctl.bpen;
  assign force_tag_o   = ctl.ftag;
  assign clk_sel_o     = ctl.clksel;
  assign bp_addr_o     = match;
endmodule

// File: tb/test_dbgctl_regs.sv
module test_dbgctl_regs;
  logic        clk = 1'b0;
  logic        rst_norm = 1'b0, rst_halt = 1'b0;
  logic        c_halt = 1'b0, c_wait = 1'b0, c_sf = 1'b0, c_dv = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wd = '0;
  logic        st_rd = 1'b1;
  logic [7:0]  st_rdata;
  logic        bp_wr = 1'b0;
  logic [15:0] bp_wd = '0;
  logic        bp_rd = 1'b1;
  logic [15:0] bp_rdata, bp_addr;
  logic        permit, bpen, ftag, clksel;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic e_pm = 0, e_ha = 0, e_be = 0, e_ft = 0, e_cs = 0, e_wt = 0, e_sf = 0, e_dv = 0;
  logic [15:0] e_bp = '0;

  always #4 clk = ~clk;

  dbgctl_regs #(.AW(16)) i_dbgctl_regs (
    .clk_i(clk), .rst_norm_i(rst_norm), .rst_halt_i(rst_halt),
    .core_halted_i(c_halt), .core_wait_i(c_wait), .core_stopfail_i(c_sf), .core_dvfail_i(c_dv),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wd), .stat_rd_i(st_rd), .stat_rdata_o(st_rdata),
    .bp_wr_i(bp_wr), .bp_wdata_i(bp_wd), .bp_rd_i(bp_rd), .bp_rdata_o(bp_rdata),
    .halt_permit_o(permit), .bp_enable_o(bpen), .force_tag_o(ftag), .clk_sel_o(clksel),
    .bp_addr_o(bp_addr)
  );

  function automatic logic [7:0] e_word();
    return {e_pm, e_ha, e_be, e_ft, e_cs, e_wt, e_sf, e_dv};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model for the coming edge, check after it
  task automatic step(bit w, logic [7:0] wd, bit bw, logic [15:0] bwd, logic [3:0] core);
    logic old_ha;
    ctl_wr = w; ctl_wd = wd; bp_wr = bw; bp_wd = bwd;
    {c_halt, c_wait, c_sf, c_dv} = core;
    old_ha = e_ha;
    if (rst_norm) begin
      {e_pm, e_ha, e_be, e_ft, e_cs, e_wt, e_sf, e_dv} = 8'h00; e_bp = '0;
    end else if (rst_halt) begin
      {e_pm, e_ha, e_be, e_ft, e_cs, e_wt, e_sf, e_dv} = 8'hC8; e_bp = '0;
    end else begin
      {e_ha, e_wt, e_sf, e_dv} = core;
      if (w) begin
        e_be = wd[5]; e_ft = wd[4]; e_cs = wd[3];
        if (wd[7] && !old_ha) e_pm = 1'b1;
      end
      if (bw) e_bp = bwd;
    end
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 0; bp_wr = 0;
  endtask

  task automatic check_all(string tag);
    #1;
    chk({tag, " word"}, {24'h0, st_rdata}, {24'h0, e_word()});
    chk({tag, " R10 pins"}, {28'h0, permit, bpen, ftag, clksel}, {28'h0, e_pm, e_be, e_ft, e_cs});
    chk({tag, " R10 bp_addr"}, {16'h0, bp_addr}, {16'h0, e_bp});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: normal reset
    rst_norm = 1;
    step(0, 8'h0, 0, '0, 4'h0);
    step(0, 8'h0, 0, '0, 4'h0);
    check_all("R1 normal reset");
    chk("R1 bp read", {16'h0, bp_rdata}, 32'h0);
    rst_norm = 0;

    // R3 R4 R5 R7: full write sweep while not halted
    for (int v = 0; v < 256; v++) begin
      step(1, v[7:0], 0, '0, {1'b0, 3'((v * 5) & 7)});
      check_all("R3/R4/R5/R7 sweep");
    end
    chk("R5 permit sticky", {31'h0, permit}, 32'h1);
    step(1, 8'h00, 0, '0, 4'h0);
    chk("R5 write 0 keeps permit", {31'h0, permit}, 32'h1);

    // R6: halted flag locks the permit bit
    rst_norm = 1; step(0, 8'h0, 0, '0, 4'h0); rst_norm = 0;
    step(0, 8'h0, 0, '0, 4'h8);
    for (int v = 0; v < 256; v++) begin
      step(1, v[7:0], 0, '0, {1'b1, 3'(v & 7)});
      check_all("R6 locked sweep");
    end
    chk("R6 permit stayed 0", {31'h0, permit}, 32'h0);

    // R9 R8: match address patterns
    for (int b = 0; b < 16; b++) begin
      step(0, 8'h0, 1, 16'(1 << b), 4'h0);
      chk("R9 one-hot load", {16'h0, bp_rdata}, {16'h0, e_bp});
      step(0, 8'h0, 1, 16'(~(1 << b)), 4'h0);
      chk("R9 one-cold load", {16'h0, bp_rdata}, {16'h0, e_bp});
    end
    step(0, 8'h0, 1, 16'hA5C3, 4'h0);
    check_all("R9 pattern");
    st_rd = 0; bp_rd = 0; #1;
    chk("R8 no status read", {24'h0, st_rdata}, 32'h0);
    chk("R8 no bp read", {16'h0, bp_rdata}, 32'h0);
    st_rd = 1; bp_rd = 1; #1;
    chk("R8 bp read", {16'h0, bp_rdata}, 32'hA5C3);

    // R2: halt-entry reset
    step(1, 8'h38, 0, '0, 4'h0);
    rst_halt = 1;
    step(0, 8'h0, 0, '0, 4'h8);
    check_all("R2 halt reset");
    chk("R2 image", {24'h0, st_rdata}, 32'hC8);
    rst_halt = 0;
    step(1, 8'h00, 0, '0, 4'h8);
    check_all("R5/R6 after halt reset");
    chk("R5 permit kept", {31'h0, permit}, 32'h1);

    // R11: both resets
    step(0, 8'h0, 1, 16'h1234, 4'h8);
    rst_norm = 1; rst_halt = 1;
    step(0, 8'h0, 0, '0, 4'hF);
    chk("R11 both resets", {24'h0, st_rdata}, 32'h00);
    check_all("R11 both resets");
    rst_norm = 0; rst_halt = 0;
    step(0, 8'h0, 0, '0, 4'h7);
    check_all("R3 after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule